// File: doc/BRIEF.md
# Compare-Match Operating-System Timer

This block is a system tick source for an operating system. A free-running up-counter advances at a fixed tick rate. The tick rate is derived from the system clock by an internal prescaler. Software loads a match value, which arms exactly one event. The event fires on the tick that brings the counter to that value. If the counter must first wrap through zero to reach the value, it wraps and the event still fires.

When the event fires and interrupts are enabled, a sticky status bit is set and a level interrupt goes high. Software acknowledges the event by writing zero to the status register. After that it usually writes the next match value to schedule the next tick.

The register port is a single-cycle slave port. It takes full 32-bit words only. A write takes effect at the clock edge where select and write are both high. Read data is a combinational function of the address. The counter is read-only. Reads of unused addresses return zero, and writes to them do nothing.

Top module: `ostmr_top`

## Requirements
- R1: The match register (byte address 0x00) and the interrupt-enable register (0x1C, all 32 bits) read back what was last written. The match register holds only the low CNT_W bits of the written word and reads back zero-extended. The status register is at 0x14, and the counter reads at 0x10.
- R2: Reads of any address other than 0x00, 0x10, 0x14 and 0x1C return zero. Writes to those addresses, and writes to the counter address 0x10, change no register.
- R3: While reset is asserted, the match, counter, status and interrupt-enable registers all read zero, and the interrupt output is low.
- R4: The counter advances by one every CLK_HZ/TICK_HZ clock cycles and wraps from 2^CNT_W-1 to zero.
- R5: A write of value M arms one event. If M is greater than the counter after that edge, the event fires after M minus that counter value ticks. At the firing edge, the counter becomes M.
- R6: If M is less than or equal to the counter, the event waits for the counter to wrap. The wait is (M - counter) mod 2^CNT_W ticks, or a full 2^CNT_W ticks when the two are equal.
- R7: When the event fires and the interrupt-enable register is nonzero, the status register reads 1 and the interrupt output goes high.
- R8: When the event fires and the interrupt-enable register is zero, the status register stays 0 and the interrupt output stays low. Enabling interrupts afterwards does not raise them.
- R9: Writing zero to the status register while it reads 1 clears it, and the interrupt output drops on the same edge.
- R10: Writing a nonzero value to the status register leaves the status unchanged.
- R11: After an event fires, later passes of the counter through the match value raise nothing until the match register is written again.
- R12: If a status clear and a firing event with interrupts enabled fall on the same edge, the status stays 1.
- R13: The interrupt output is registered, and it equals the status bit AND (interrupt-enable register nonzero). Writing the enable register to zero drops the interrupt while the status stays 1. Writing it nonzero again raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench checks the event timing from both sides of the wrap. A match value just above the counter must fire after exactly that many ticks. A value below the counter, or equal to it, must wait through a full wrap. A design that compared with greater-or-equal, or that fired on the write itself, would raise the interrupt thousands of cycles early. The bench also lets the counter run a full lap after an event to catch a design that re-fires on every pass. Status writes are aimed at two cases: a nonzero write, which a careless decode would treat as a clear, and a clear on the same edge as a new event, which must lose. With interrupts disabled, an event must leave no latent status that appears once enabling is turned back on.

// File: rtl/ostmr_pkg.sv
`timescale 1ns/1ps
package ostmr_pkg;
   localparam int unsigned DATA_W = 32;

   // byte offsets of the 32-bit registers
   localparam logic [7:0] OFS_MATCH  = 8'h00;
   localparam logic [7:0] OFS_COUNT  = 8'h10;
   localparam logic [7:0] OFS_STATUS = 8'h14;
   localparam logic [7:0] OFS_IEN    = 8'h1C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MATCH,
      SEL_COUNT,
      SEL_STATUS,
      SEL_IEN
   } ostmr_sel_e;
endpackage

// File: rtl/ostmr_prescale.sv
`timescale 1ns/1ps
module ostmr_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_bypass
         logic unused_in;
         assign unused_in = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (pre_q == LAST)
               pre_q <= '0;
            else
               pre_q <= pre_q + PW'(1);
         end

         assign tick = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ostmr_cmp.sv
`timescale 1ns/1ps
module ostmr_cmp #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             match_we,
   input  logic [CNT_W-1:0] match_wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] match_q,
   output logic             armed_q,
   output logic             fire
);
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + CNT_W'(1);

   // An event fires on the tick whose new count equals the match value.
   // A match write in the same cycle re-arms instead of firing.
   assign fire = tick & armed_q & ~match_we & (cnt_inc == match_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         match_q <= '0;
         armed_q <= 1'b0;
      end else begin
         if (tick)
            cnt_q <= cnt_inc;
         if (match_we) begin
            match_q <= match_wdata;
            armed_q <= 1'b1;
         end else if (fire) begin
            armed_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ostmr_regs.sv
`timescale 1ns/1ps
module ostmr_regs
   import ostmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [CNT_W-1:0]  match_q,
   input  logic              fire,
   output logic              match_we,
   output logic [CNT_W-1:0]  match_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              status_q,
   output logic [DATA_W-1:0] ien_q,
   output logic              irq_q
);
   localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_IEN    = ADDR_W'(OFS_IEN);

   ostmr_sel_e        sel;
   logic              wr_en;
   logic              st_set;
   logic              st_clr;
   logic              status_d;
   logic [DATA_W-1:0] ien_d;
   logic [DATA_W-1:0] cnt_ext;
   logic [DATA_W-1:0] match_ext;

   always_comb begin
      sel = SEL_NONE;
      if (bus_sel) begin
         if (bus_addr == A_MATCH)       sel = SEL_MATCH;
         else if (bus_addr == A_COUNT)  sel = SEL_COUNT;
         else if (bus_addr == A_STATUS) sel = SEL_STATUS;
         else if (bus_addr == A_IEN)    sel = SEL_IEN;
      end
   end

   assign wr_en       = bus_sel & bus_wr;
   assign match_we    = wr_en & (sel == SEL_MATCH);
   assign match_wdata = bus_wdata[CNT_W-1:0];

   // zero extension of the narrow counter fields
   generate
      if (CNT_W == DATA_W) begin : g_full
         assign cnt_ext   = cnt_q;
         assign match_ext = match_q;
      end else begin : g_narrow
         assign cnt_ext   = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
         assign match_ext = {{(DATA_W-CNT_W){1'b0}}, match_q};
      end
   endgenerate

   // a firing event outranks a clear on the same edge
   assign st_set = fire & (|ien_q);
   assign st_clr = wr_en & (sel == SEL_STATUS) & (bus_wdata == '0);

   always_comb begin
      status_d = status_q;
      if (st_set)
         status_d = 1'b1;
      else if (st_clr)
         status_d = 1'b0;
   end

   assign ien_d = (wr_en && sel == SEL_IEN) ? bus_wdata : ien_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         ien_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         ien_q    <= ien_d;
         irq_q    <= status_d & (|ien_d);
      end
   end

   always_comb begin
      unique case (sel)
         SEL_MATCH:  bus_rdata = match_ext;
         SEL_COUNT:  bus_rdata = cnt_ext;
         SEL_STATUS: bus_rdata = {{(DATA_W-1){1'b0}}, status_q};
         SEL_IEN:    bus_rdata = ien_q;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ostmr_top.sv
`timescale 1ns/1ps
module ostmr_top
   import ostmr_pkg::*;
#(
   parameter int unsigned CLK_HZ  = 200_000_000,
   parameter int unsigned TICK_HZ = 50_000_000,
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   localparam int unsigned DIV = CLK_HZ / TICK_HZ;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("ostmr_top: CNT_W must lie in 2..32");
      end
      if (TICK_HZ == 0 || CLK_HZ < TICK_HZ || (CLK_HZ % TICK_HZ) != 0) begin : g_bad_rate
         $error("ostmr_top: CLK_HZ must be a whole multiple of TICK_HZ");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("ostmr_top: ADDR_W must reach byte offset 0x1C");
      end
   endgenerate

   logic              tick;
   logic              match_we;
   logic [CNT_W-1:0]  match_wdata;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  match_q;
   logic              armed_q;
   logic              fire;
   logic              status_q;
   logic [DATA_W-1:0] ien_q;

   ostmr_prescale #(.DIV(DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   ostmr_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .match_we    (match_we),
      .match_wdata (match_wdata),
      .cnt_q       (cnt_q),
      .match_q     (match_q),
      .armed_q     (armed_q),
      .fire        (fire)
   );

   ostmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .cnt_q       (cnt_q),
      .match_q     (match_q),
      .fire        (fire),
      .match_we    (match_we),
      .match_wdata (match_wdata),
      .bus_rdata   (bus_rdata),
      .status_q    (status_q),
      .ien_q       (ien_q),
      .irq_q       (irq_o)
   );
endmodule

// File: rtl/ostmr_top_chk.sv
`timescale 1ns/1ps
module ostmr_top_chk
   import ostmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  match_q,
   input logic              status_q,
   input logic [31:0]       ien_q,
   input logic              armed_q,
   input logic              tick,
   input logic              fire
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

   logic clr_wr;
   assign clr_wr = bus_sel & bus_wr & (bus_addr == A_STATUS) & (bus_wdata == '0);

   assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

   assert_fire_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q) |-> cnt_q == match_q);

   assert_irq_level_R13: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (status_q && ien_q != '0));

   assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !clr_wr) |=> status_q);

   assert_one_shot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed_q);

   assert_masked_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ien_q == '0 && !status_q) |=> !status_q);
endmodule

bind ostmr_top ostmr_top_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .cnt_q     (cnt_q),
   .match_q   (match_q),
   .status_q  (status_q),
   .ien_q     (ien_q),
   .armed_q   (armed_q),
   .tick      (tick),
   .fire      (fire)
);

// File: tb/ostmr_top_test.sv
`timescale 1ns/1ps
module ostmr_top_test;
   localparam int CNT_W   = 10;
   localparam int CNT_MOD = 1 << CNT_W;
   localparam int DIV     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ostmr_top #(.CLK_HZ(200_000_000), .TICK_HZ(50_000_000), .CNT_W(CNT_W), .ADDR_W(5)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   // reference model: a countdown of remaining ticks per armed event
   int          m_pre, m_cnt, m_mt, m_wait, m_fires;
   bit          m_arm, m_st, m_irq;
   logic [31:0] m_ie;

   always @(posedge clk) begin
      bit tick_now, mw, fire_now;
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_mt = 0; m_wait = 0; m_fires = 0;
         m_arm = 0; m_st = 0; m_irq = 0; m_ie = '0;
      end else begin
         tick_now = (m_pre == DIV - 1);
         m_pre    = tick_now ? 0 : m_pre + 1;
         if (tick_now) m_cnt = (m_cnt + 1) % CNT_MOD;
         mw = bus_sel && bus_wr && bus_addr == 5'h00;
         fire_now = 0;
         if (m_arm && tick_now && !mw) begin
            m_wait = m_wait - 1;
            if (m_wait == 0) begin fire_now = 1; m_arm = 0; end
         end
         if (mw) begin
            m_mt   = int'(bus_wdata % CNT_MOD);
            m_wait = (m_mt - m_cnt + CNT_MOD) % CNT_MOD;
            if (m_wait == 0) m_wait = CNT_MOD;
            m_arm  = 1;
         end
         if (fire_now && m_ie != 0) m_st = 1;
         else if (bus_sel && bus_wr && bus_addr == 5'h14 && bus_wdata == 0) m_st = 0;
         if (bus_sel && bus_wr && bus_addr == 5'h1C) m_ie = bus_wdata;
         m_irq = m_st && (m_ie != 0);
         if (fire_now) m_fires = m_fires + 1;
      end
   end

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a)
         5'h00:   return 32'(m_mt);
         5'h10:   return 32'(m_cnt);
         5'h14:   return {31'b0, m_st};
         5'h1C:   return m_ie;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle interrupt comparison against the model (R13)
   always @(negedge clk) begin
      if (rst_n) chk("R13 irq level vs model", {31'b0, irq_o}, {31'b0, m_irq});
   end

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic read_model(input string tag, input logic [4:0] a);
      logic [31:0] d;
      bus_read(a, d);
      chk(tag, d, model_read(a));
   endtask

   // returns at the negedge just before a tick edge
   task automatic sync_tick;
      do @(negedge clk); while (m_pre != DIV - 1);
   endtask

   task automatic wait_fire(input string tag, output int n);
      int start;
      start = m_fires;
      n = 0;
      while (m_fires == start && n < 20000) begin
         @(negedge clk);
         n++;
      end
      if (m_fires == start) chk({tag, " event timeout"}, 32'd0, 32'd1);
   endtask

   // arm an event at offset ahead of the present counter; returns the match value
   task automatic arm_ahead(input int ahead, output int mv);
      logic [31:0] c;
      sync_tick;
      bus_read(5'h10, c);
      mv = (int'(c) + ahead) % CNT_MOD;
      bus_write(5'h00, 32'(mv));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d, c0;
      int mv, n;

      // R3: reset state
      repeat (3) @(negedge clk);
      bus_read(5'h00, d); chk("R3 match in reset", d, 0);
      bus_read(5'h10, d); chk("R3 counter in reset", d, 0);
      bus_read(5'h14, d); chk("R3 status in reset", d, 0);
      bus_read(5'h1C, d); chk("R3 ien in reset", d, 0);
      chk("R3 irq in reset", {31'b0, irq_o}, 0);
      @(negedge clk); rst_n = 1;

      // R4: counter rate
      repeat (37) @(negedge clk);
      read_model("R4 counter vs model", 5'h10);
      sync_tick;
      bus_read(5'h10, c0);
      repeat (7) @(negedge clk);
      bus_read(5'h10, d);
      chk("R4 two ticks in eight clocks", d, c0 + 2);

      // R1: readback
      bus_write(5'h00, 32'h0000_0ABC);
      bus_read(5'h00, d); chk("R1 match truncated readback", d, 32'h0000_02BC);
      bus_write(5'h1C, 32'hA5A5_0003);
      bus_read(5'h1C, d); chk("R1 ien readback", d, 32'hA5A5_0003);
      bus_write(5'h1C, 32'h0);

      // R2: unmapped and read-only addresses
      bus_write(5'h04, 32'hFFFF_FFFF);
      bus_write(5'h10, 32'h0000_0155);
      bus_write(5'h18, 32'h1234_5678);
      bus_read(5'h04, d); chk("R2 unmapped 0x04 reads zero", d, 0);
      bus_read(5'h08, d); chk("R2 unmapped 0x08 reads zero", d, 0);
      bus_read(5'h18, d); chk("R2 unmapped 0x18 reads zero", d, 0);
      read_model("R2 counter unaffected by write", 5'h10);
      bus_read(5'h00, d); chk("R2 match unaffected", d, 32'h0000_02BC);
      bus_read(5'h1C, d); chk("R2 ien unaffected", d, 0);

      // R5 and R7: forward event with interrupts enabled
      bus_write(5'h1C, 32'h1);
      arm_ahead(20, mv);
      wait_fire("R5", n);
      chk("R5 wait length lower bound", {31'b0, n > 4 * 19}, 1);
      chk("R5 wait length upper bound", {31'b0, n <= 4 * 21}, 1);
      bus_read(5'h10, d); chk("R5 counter equals match at event", d, 32'(mv));
      bus_read(5'h14, d); chk("R7 status set", d, 1);
      chk("R7 irq high", {31'b0, irq_o}, 1);

      // R10: nonzero status write ignored
      bus_write(5'h14, 32'h5);
      bus_read(5'h14, d); chk("R10 status kept after nonzero write", d, 1);
      chk("R10 irq kept", {31'b0, irq_o}, 1);

      // R9: clear
      bus_write(5'h14, 32'h0);
      bus_read(5'h14, d); chk("R9 status cleared", d, 0);
      chk("R9 irq dropped", {31'b0, irq_o}, 0);

      // R11: a full lap raises nothing
      repeat (4 * CNT_MOD + 100) @(negedge clk);
      bus_read(5'h14, d); chk("R11 no refire after a lap", d, 0);
      chk("R11 irq low after a lap", {31'b0, irq_o}, 0);

      // R6: match below the counter waits for the wrap
      arm_ahead(CNT_MOD - 5, mv);
      wait_fire("R6", n);
      chk("R6 wrap wait lower bound", {31'b0, n > 4 * 1000}, 1);
      bus_read(5'h10, d); chk("R6 counter equals match after wrap", d, 32'(mv));
      bus_read(5'h14, d); chk("R6 status set after wrap", d, 1);
      bus_write(5'h14, 32'h0);

      // R6: match equal to the counter waits a full lap
      arm_ahead(0, mv);
      wait_fire("R6 equal", n);
      chk("R6 equal-value wait is a full lap", {31'b0, n > 4 * (CNT_MOD - 2)}, 1);
      read_model("R6 status after full lap", 5'h14);
      bus_write(5'h14, 32'h0);

      // R12: clear on the same edge as a new event
      arm_ahead(3, mv);
      wait_fire("R12 setup", n);
      arm_ahead(3, mv);
      do @(negedge clk); while (!(m_arm && m_pre == DIV - 1 && m_wait == 1));
      bus_sel = 1; bus_wr = 1; bus_addr = 5'h14; bus_wdata = 32'h0;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
      bus_read(5'h14, d); chk("R12 event wins over clear", d, 1);
      chk("R12 irq stays high", {31'b0, irq_o}, 1);

      // R13: enable gates the interrupt level
      bus_write(5'h1C, 32'h0);
      chk("R13 irq drops with enable cleared", {31'b0, irq_o}, 0);
      bus_read(5'h14, d); chk("R13 status held while masked", d, 1);
      bus_write(5'h1C, 32'h8000_0000);
      chk("R13 irq returns with enable set", {31'b0, irq_o}, 1);
      bus_write(5'h14, 32'h0);

      // R8: event while disabled
      bus_write(5'h1C, 32'h0);
      arm_ahead(4, mv);
      wait_fire("R8", n);
      bus_read(5'h14, d); chk("R8 status clear when disabled", d, 0);
      chk("R8 irq low when disabled", {31'b0, irq_o}, 0);
      bus_write(5'h1C, 32'h1);
      bus_read(5'h14, d); chk("R8 no latent status after enabling", d, 0);
      chk("R8 irq low after enabling", {31'b0, irq_o}, 0);

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule